// File: doc/BRIEF.md
# Serial Autobaud Detector

This block listens to an idle-high asynchronous serial line and works out both the bit rate and the frame format from a short calibration burst. Software arms the detector, then has the remote end send two carriage-return characters (0x0D) back to back, each with one stop bit. The falling edge that opens the first start bit starts a width counter. The next rising edge stops it, because bit 0 of 0x0D is 1. That count, in system clocks, is the bit period. A shift register then takes eleven samples, each at the centre of a bit slot: the first is half a measured period after the rising edge, and each later one is a full period after the one before it.

Slot positions are counted from the first data bit (position 0). Positions 0 to 6 must read 1,0,1,1,0,0,0. The frame is then classified by where the first stop bit falls and where the second character's start bit falls:

| Positions 7..10 | Result |
|---|---|
| 1,0,x,x | 7 bits, no parity |
| 1,1,0,x | 7 bits, even parity |
| 0,1,0,x | 8 bits, no parity |
| 0,1,1,0 | 8 bits, even parity |
| 0,0,1,0 | 8 bits, odd parity |

Seven-bit odd parity cannot be told apart from 8-bit no parity with this character, so it is not reported. The results are held for software, which uses them to program a separate UART.

Top module: `autobaud_det`

## Requirements
- R1: A one-cycle `arm_i` pulse clears `done_o` and `err_o` on the next clock edge. The detector then waits for the line to be high before it looks for a falling edge.
- R2: `bit_time_o` equals the start-bit width, measured in system clocks from the falling edge to the next rising edge. At 200 MHz and 115.2 kbit/s this is 1736.
- R3: `len8_o` is 1 for 8-bit characters and 0 for 7-bit characters, following the table above.
- R4: `parity_o` encodes the parity as 2'b00 none, 2'b01 even and 2'b10 odd. The value 2'b11 never appears.
- R5: A start-bit width below `MIN_CNT` clocks sets `err_o` and gives no result. A width of exactly `MIN_CNT` is accepted.
- R6: If the line stays low for `MAX_CNT` clocks after a falling edge, `err_o` is set and no result is given.
- R7: If the samples at positions 0 to 6 differ from 1,0,1,1,0,0,0, or if positions 7 to 10 match no row of the table, `err_o` is set and no result is given.
- R8: After any error the detector keeps hunting without being re-armed. A later valid burst still completes, and `err_o` stays set until the next `arm_i`.
- R9: While `done_o` is 1, line activity changes neither `done_o` nor any result output until the next `arm_i`.
- R10: After reset, `done_o` and `err_o` are 0 and the detector ignores the line until it is first armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | One-cycle pulse that clears the flags and starts a new detection |
| rxd_i | input | 1 | Asynchronous serial input, high when idle |
| done_o | output | 1 | Detection complete; the results are valid and held |
| err_o | output | 1 | Sticky error flag (width too short, timeout, or unrecognised frame) |
| bit_time_o | output | CNT_W | Measured bit period in system clocks |
| len8_o | output | 1 | 1 for 8 data bits, 0 for 7 data bits |
| parity_o | output | 2 | Parity: 00 none, 01 even, 10 odd |

## Verification
On every cycle, the assertions check the following:
- arming clears both flags;
- the results and `done_o` stay frozen while done;
- the error flag is sticky;
- a reported bit time never falls below the minimum;
- the width counter never passes the timeout;
- the parity code never takes its unused value;
- the sampler's slot index stays inside its eleven positions.

Other behaviour can only be shown by the bench's scenarios:
- the measured period matches the drive exactly;
- each of the five formats is recognised at random bit periods;
- both boundary widths and the 115.2 kbit/s rate are handled;
- the detector recovers after a wrong calibration character.

// File: rtl/abd_pkg.sv
package abd_pkg;
  localparam int NSAMP = 11;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10
  } par_e;

  typedef struct packed {
    logic ok;
    logic len8;
    par_e par;
  } fmt_t;

  // Classify eleven mid-bit samples (bit 0 = first data slot).
  function automatic fmt_t classify(input logic [NSAMP-1:0] s);
    fmt_t f;
    f.ok   = 1'b0;
    f.len8 = 1'b0;
    f.par  = PAR_NONE;
    if (s[6:0] == 7'b0001101) begin
      if (s[7] && !s[8]) begin
        f.ok = 1'b1;
      end else if (s[7] && s[8] && !s[9]) begin
        f.ok = 1'b1; f.par = PAR_EVEN;
      end else if (!s[7] && s[8] && !s[9]) begin
        f.ok = 1'b1; f.len8 = 1'b1;
      end else if (!s[7] && s[8] && s[9] && !s[10]) begin
        f.ok = 1'b1; f.len8 = 1'b1; f.par = PAR_EVEN;
      end else if (!s[7] && !s[8] && s[9] && !s[10]) begin
        f.ok = 1'b1; f.len8 = 1'b1; f.par = PAR_ODD;
      end
    end
    return f;
  endfunction
endpackage

// File: rtl/abd_edge.sv
module abd_edge (
  input  logic clk,
  input  logic rst,
  input  logic rxd_i,
  output logic lvl_o,
  output logic fall_o,
  output logic rise_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 3'b111;
    else     sync_q <= {sync_q[1:0], rxd_i};
  end

  assign lvl_o  = sync_q[1];
  assign fall_o = sync_q[2] & ~sync_q[1];
  assign rise_o = ~sync_q[2] & sync_q[1];
endmodule

// File: rtl/abd_sampler.sv
module abd_sampler #(
  parameter int CNT_W = 16,
  parameter int NSAMP = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             lvl_i,
  output logic [NSAMP-1:0] bits_o,
  output logic             done_o
);
  localparam int IDX_W = $clog2(NSAMP + 1);

  logic             active;
  logic [CNT_W-1:0] tmr, tgt, per_q;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      tmr    <= '0;
      tgt    <= '0;
      per_q  <= '0;
      idx    <= '0;
      bits_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        active <= 1'b0;
      end else if (start_i) begin
        active <= 1'b1;
        tmr    <= {{(CNT_W-1){1'b0}}, 1'b1};
        tgt    <= period_i >> 1;
        per_q  <= period_i;
        idx    <= '0;
      end else if (active) begin
        if (tmr == tgt) begin
          bits_o <= {lvl_i, bits_o[NSAMP-1:1]};
          tmr    <= {{(CNT_W-1){1'b0}}, 1'b1};
          tgt    <= per_q;
          if (idx == IDX_W'(NSAMP - 1)) begin
            active <= 1'b0;
            done_o <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end

  p_slot_range_r7: assert property (@(posedge clk) disable iff (rst)
    active |-> (idx < IDX_W'(NSAMP)));
  p_timer_bound_r2: assert property (@(posedge clk) disable iff (rst)
    active |-> (tmr <= tgt));
endmodule

// File: rtl/autobaud_det.sv
module autobaud_det #(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 8,
  parameter int MAX_CNT = 60000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             rxd_i,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] bit_time_o,
  output logic             len8_o,
  output logic [1:0]       parity_o
);
  import abd_pkg::*;

  typedef enum logic [2:0] {ST_OFF, ST_HIGH, ST_HUNT, ST_MEAS, ST_SAMP, ST_DONE} st_e;

  st_e              state;
  logic             lvl, fall, rise;
  logic [CNT_W-1:0] wcnt;
  logic [NSAMP-1:0] samples;
  logic             samp_done, samp_go;
  fmt_t             fmt;

  abd_edge u_edge (
    .clk(clk), .rst(rst), .rxd_i(rxd_i),
    .lvl_o(lvl), .fall_o(fall), .rise_o(rise)
  );

  assign samp_go = (state == ST_MEAS) && rise && (wcnt >= CNT_W'(MIN_CNT));

  abd_sampler #(.CNT_W(CNT_W), .NSAMP(NSAMP)) u_samp (
    .clk(clk), .rst(rst), .start_i(samp_go), .abort_i(arm_i),
    .period_i(wcnt), .lvl_i(lvl), .bits_o(samples), .done_o(samp_done)
  );

  assign fmt = classify(samples);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OFF;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      wcnt       <= '0;
      bit_time_o <= '0;
      len8_o     <= 1'b0;
      parity_o   <= PAR_NONE;
    end else if (arm_i) begin
      state  <= ST_HIGH;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      case (state)
        ST_HIGH: if (lvl) state <= ST_HUNT;
        ST_HUNT: if (fall) begin
          wcnt  <= {{(CNT_W-1){1'b0}}, 1'b1};
          state <= ST_MEAS;
        end
        ST_MEAS: begin
          if (rise) begin
            if (wcnt < CNT_W'(MIN_CNT)) begin
              err_o <= 1'b1;
              state <= ST_HIGH;
            end else begin
              state <= ST_SAMP;
            end
          end else if (wcnt >= CNT_W'(MAX_CNT)) begin
            err_o <= 1'b1;
            state <= ST_HIGH;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_SAMP: if (samp_done) begin
          if (fmt.ok) begin
            bit_time_o <= wcnt;
            len8_o     <= fmt.len8;
            parity_o   <= fmt.par;
            done_o     <= 1'b1;
            state      <= ST_DONE;
          end else begin
            err_o <= 1'b1;
            state <= ST_HIGH;
          end
        end
        default: state <= state;
      endcase
    end
  end

  p_arm_clears_r1: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (!done_o && !err_o));
  p_hold_results_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o && !arm_i) |=> (done_o && $stable(bit_time_o) && $stable(len8_o) && $stable(parity_o)));
  p_min_width_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (bit_time_o >= CNT_W'(MIN_CNT)));
  p_timeout_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MEAS) |-> (wcnt <= CNT_W'(MAX_CNT)));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (err_o && !arm_i) |=> err_o);
  p_par_code_r4: assert property (@(posedge clk) disable iff (rst)
    parity_o != 2'b11);
endmodule

// File: tb/autobaud_det_tb.sv
module autobaud_det_tb;
  localparam int CW = 16;
  localparam int MINC = 8;
  localparam int MAXC = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0;
  logic rxd = 1'b1;
  logic done, err, len8;
  logic [CW-1:0] bt;
  logic [1:0] par;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  autobaud_det #(.CNT_W(CW), .MIN_CNT(MINC), .MAX_CNT(MAXC)) u_dut (
    .clk(clk), .rst(rst), .arm_i(arm), .rxd_i(rxd),
    .done_o(done), .err_o(err), .bit_time_o(bt), .len8_o(len8), .parity_o(par)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // fmt: 0=7N 1=7E 2=8N 3=8E 4=8O
  function automatic int exp_len8(input int fmt);
    return (fmt >= 2) ? 1 : 0;
  endfunction
  function automatic int exp_par(input int fmt);
    case (fmt)
      1, 3: return 1;
      4: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic send_bit(input logic b, input int t);
    rxd = b;
    repeat (t) @(negedge clk);
  endtask

  // One character of given data value in the given format.
  task automatic send_char(input logic [7:0] d, input int fmt, input int t);
    int nb = (fmt >= 2) ? 8 : 7;
    logic p = 1'b0;
    send_bit(1'b0, t);
    for (int i = 0; i < nb; i++) begin
      send_bit(d[i], t);
      p ^= d[i];
    end
    if (fmt == 1 || fmt == 3) send_bit(p, t);
    if (fmt == 4) send_bit(~p, t);
    send_bit(1'b1, t);
  endtask

  task automatic run_pair(input int fmt, input int t, input bit exp_err);
    do_arm();
    idle(4);
    chk(done == 1'b0 && err == 1'b0, "R1 flags cleared by arm", {done, err}, 0);
    send_char(8'h0D, fmt, t);
    send_char(8'h0D, fmt, t);
    rxd = 1'b1;
    idle(2 * t + 20);
    chk(done == 1'b1, "R2 done after burst", done, 1);
    chk(bt == CW'(t), "R2 bit time", bt, t);
    chk(len8 == exp_len8(fmt), "R3 length", len8, exp_len8(fmt));
    chk(par == exp_par(fmt), "R4 parity code", par, exp_par(fmt));
    chk(err == exp_err, "R8 error flag state", err, exp_err);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle(5);
    rst = 1'b0;
    idle(3);
    chk(done == 1'b0 && err == 1'b0 && bt == '0, "R10 reset state", {done, err}, 0);
    // R10: unarmed detector ignores a valid burst
    send_char(8'h0D, 2, 40);
    send_char(8'h0D, 2, 40);
    rxd = 1'b1;
    idle(100);
    chk(done == 1'b0 && err == 1'b0, "R10 ignored before arm", {done, err}, 0);

    // Directed: every format once
    for (int f = 0; f < 5; f++) run_pair(f, 64 + 8 * f, 1'b0);

    // R9: activity while done is ignored
    send_char(8'h41, 0, 20);
    rxd = 1'b1;
    idle(50);
    chk(done == 1'b1 && bt == CW'(96), "R9 results held", bt, 96);
    chk(len8 == 1'b1 && par == 2'd2, "R9 format held", {len8, par}, 6);

    // Random formats and periods
    for (int k = 0; k < 8; k++) begin
      int f = $urandom_range(4, 0);
      int t = $urandom_range(200, 40);
      run_pair(f, t, 1'b0);
    end

    // R5: minimum width accepted exactly
    run_pair(3, MINC, 1'b0);
    // R2: 115.2 kbit/s at 200 MHz
    run_pair(1, 1736, 1'b0);

    // R5: too-short start bit
    do_arm();
    idle(4);
    send_bit(1'b0, MINC - 1);
    rxd = 1'b1;
    idle(20);
    chk(err == 1'b1 && done == 1'b0, "R5 short width error", {done, err}, 1);

    // R6: line held low past the timeout
    do_arm();
    idle(4);
    send_bit(1'b0, MAXC + 50);
    chk(err == 1'b1 && done == 1'b0, "R6 timeout error", {done, err}, 1);
    rxd = 1'b1;
    idle(20);

    // R7: wrong calibration character, then R8 recovery without arm
    do_arm();
    idle(4);
    send_char(8'h41, 2, 50);
    rxd = 1'b1;
    idle(50 * 14);
    chk(err == 1'b1 && done == 1'b0, "R7 bad character error", {done, err}, 1);
    send_char(8'h0D, 0, 50);
    send_char(8'h0D, 0, 50);
    rxd = 1'b1;
    idle(120);
    chk(done == 1'b1 && bt == CW'(50), "R8 recovery result", bt, 50);
    chk(err == 1'b1, "R8 error stays set", err, 1);

    // R1: arm clears the held error and result
    do_arm();
    chk(done == 1'b0 && err == 1'b0, "R1 arm clears both", {done, err}, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule